// File: doc/BRIEF.md
# GPIO Event Interrupt Router

This block sits behind a 32-pin GPIO controller and decides where each pin's edge event goes. Routing happens in two steps. The first step sends each pin to one of eight event pairs, or diverts it to a single power-management event (PME) output. The second step sends each event pair to one of sixteen interrupt request lines.

Each pin has an edge-status bit. A one-cycle pulse on that pin's event input sets the bit. Software clears it by writing a one to it. An event pair is pending while any pin routed to it has its status bit set and is not diverted to PME. Each interrupt line is a level: the OR of every pending pair that the zone-select register assigns to it.

Software programs the block through a simple register bus:
- Four map registers, one for each group of eight pins, hold one 4-bit field per pin.
- A zone-select register holds one 4-bit IRQ number per pair.
- A status register holds the pins' edge-status bits.

Writes take effect at the clock edge. Reads are combinational.

Top module: `gpio_evt_router`

## Requirements
- R1: After reset, all map registers, the zone-select register and the status register read zero, all `irq_o` lines are low and `pme_o` is low.
- R2: A high `evt_i[n]` at a clock edge sets status bit n. The bit reads as 1 at address 5 after that edge.
- R3: Writing to address 5 clears every status bit whose write-data bit is 1 and leaves the others unchanged. If an event and a clear hit the same pin in the same cycle, the event wins and the bit stays set.
- R4: Map registers sit at addresses 0 to 3 and cover pins 0–7, 8–15, 16–23 and 24–31 in that order. Pin n uses the 4-bit field at bits 4·(n mod 8)+3 : 4·(n mod 8). Bits 2:0 of that field choose the event pair, 0 to 7.
- R5: When bit 3 of a pin's field is 1, a set status bit for that pin drives `pme_o` high and drives no IRQ line.
- R6: The zone-select register sits at address 4. Bits 4g+3 : 4g give the IRQ number, 0 to 15, for pair g.
- R7: `irq_o[k]` is high exactly when at least one pending, non-PME pair has zone value k. It stays high until every contributing status bit has been cleared.
- R8: `irq_o` and `pme_o` follow the current register contents. Rewriting the zone-select or map registers while a bit is pending moves the request to its new line in the cycle after the write.
- R9: Writes to addresses 6 and 7 have no effect, and reads of addresses 6 and 7 return zero. Map and zone registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Per-pin edge event pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 16 | Interrupt request levels |
| pme_o | output | 1 | Power-management event level |

## Verification
Every output except read data is derived combinationally from three sets of registers: status, map and zone. A corrupt status bit or field therefore shows on `irq_o` or `pme_o` one cycle after the stimulus that caused it.

The dangerous failures are silent ones:
- a status bit that clears early;
- a PME field that still drives an IRQ;
- a pair that lands on the wrong line.

The bench therefore checks the exact 16-bit IRQ vector, not just whether any line is active. It also checks partial clears of shared pairs and the case where an event and a clear arrive in the same cycle.

// File: rtl/gev_pkg.sv
package gev_pkg;
    localparam int NUM_PINS     = 32;
    localparam int PINS_PER_MAP = 8;
    localparam int FIELD_W      = 4;
    localparam int NUM_PAIRS    = 8;
    localparam int NUM_IRQS     = 16;
    localparam int REG_W        = 32;
    localparam int ADDR_W       = 3;
    localparam int NUM_MAPS     = NUM_PINS / PINS_PER_MAP;
    localparam int PAIR_W       = $clog2(NUM_PAIRS);
    localparam int IRQ_W        = $clog2(NUM_IRQS);
    localparam logic [ADDR_W-1:0] ADDR_ZONE = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;
    typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/gev_regs.sv
module gev_regs
    import gev_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  word_t                        wdata_i,
    output logic [NUM_MAPS-1:0][REG_W-1:0] map_o,
    output word_t                        zone_o
);
    for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_o[m] <= '0;
            else if (wr_en_i && addr_i == ADDR_W'(m))
                map_o[m] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            zone_o <= '0;
        else if (wr_en_i && addr_i == ADDR_ZONE)
            zone_o <= wdata_i;
    end
endmodule

// File: rtl/gev_status.sv
module gev_status
    import gev_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic                clr_en_i,
    input  logic [NUM_PINS-1:0] clr_mask_i,
    output logic [NUM_PINS-1:0] stat_o
);
    logic [NUM_PINS-1:0] clr_eff;

    assign clr_eff = clr_en_i ? clr_mask_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_o <= '0;
        else
            stat_o <= (stat_o & ~clr_eff) | evt_i;
    end
endmodule

// File: rtl/gev_route.sv
module gev_route
    import gev_pkg::*;
(
    input  logic [NUM_PINS-1:0]            stat_i,
    input  logic [NUM_MAPS-1:0][REG_W-1:0] map_i,
    input  word_t                          zone_i,
    output logic [NUM_PAIRS-1:0]           pair_pend_o,
    output logic [NUM_IRQS-1:0]            irq_o,
    output logic                           pme_o
);
    logic [FIELD_W-1:0] fld;

    always_comb begin
        pair_pend_o = '0;
        pme_o       = 1'b0;
        fld         = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            fld = map_i[n / PINS_PER_MAP][(n % PINS_PER_MAP) * FIELD_W +: FIELD_W];
            if (stat_i[n]) begin
                if (fld[FIELD_W-1])
                    pme_o = 1'b1;
                else
                    pair_pend_o[fld[PAIR_W-1:0]] = 1'b1;
            end
        end
    end

    always_comb begin
        irq_o = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (pair_pend_o[p])
                irq_o[zone_i[p * IRQ_W +: IRQ_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_evt_router.sv
module gpio_evt_router
    import gev_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] evt_i,
    input  logic        wr_en_i,
    input  logic [2:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic [15:0] irq_o,
    output logic        pme_o
);
    logic [NUM_MAPS-1:0][REG_W-1:0] map_q;
    word_t                          zone_q;
    logic [NUM_PINS-1:0]            pin_stat;
    logic [NUM_PAIRS-1:0]           pair_pend;

    gev_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .map_o   (map_q),
        .zone_o  (zone_q)
    );

    gev_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (wr_en_i && addr_i == ADDR_STAT),
        .clr_mask_i (wdata_i),
        .stat_o     (pin_stat)
    );

    gev_route u_route (
        .stat_i      (pin_stat),
        .map_i       (map_q),
        .zone_i      (zone_q),
        .pair_pend_o (pair_pend),
        .irq_o       (irq_o),
        .pme_o       (pme_o)
    );

    always_comb begin
        if (addr_i < ADDR_W'(NUM_MAPS))
            rdata_o = map_q[addr_i[$clog2(NUM_MAPS)-1:0]];
        else if (addr_i == ADDR_ZONE)
            rdata_o = zone_q;
        else if (addr_i == ADDR_STAT)
            rdata_o = pin_stat;
        else
            rdata_o = '0;
    end
endmodule

// File: rtl/gev_checker.sv
module gev_checker
    import gev_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PINS-1:0]  evt_i,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [NUM_PINS-1:0]  pin_stat,
    input logic [NUM_PAIRS-1:0] pair_pend,
    input logic [NUM_IRQS-1:0]  irq_o,
    input logic                 pme_o
);
    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pin_stat & $past(evt_i)) == $past(evt_i))); // R2

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADDR_STAT) |=> ((pin_stat & $past(pin_stat)) == $past(pin_stat))); // R3

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_stat == '0) |-> (irq_o == '0 && !pme_o)); // R1

    AST_PME_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pme_o |-> (|pin_stat)); // R5

    AST_IRQ_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) == (|pair_pend)); // R7

    AST_IRQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_o) <= $countones(pair_pend)); // R6
endmodule

bind gpio_evt_router gev_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .pin_stat  (pin_stat),
    .pair_pend (pair_pend),
    .irq_o     (irq_o),
    .pme_o     (pme_o)
);

// File: tb/gpio_evt_router_bench.sv
module gpio_evt_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [15:0] irq_o;
    logic        pme_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpio_evt_router u_gpio_evt_router (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .pme_o(pme_o)
    );

    typedef struct packed {
        logic [4:0]  pin;
        logic [3:0]  nib;
        logic [31:0] zone;
        logic [15:0] irq;
        logic        pme;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{pin: 5'd0,  nib: 4'h0, zone: 32'h0000_0000, irq: 16'h0001, pme: 1'b0},
        '{pin: 5'd5,  nib: 4'h3, zone: 32'h0000_7000, irq: 16'h0080, pme: 1'b0},
        '{pin: 5'd9,  nib: 4'h6, zone: 32'h0F00_0000, irq: 16'h8000, pme: 1'b0},
        '{pin: 5'd18, nib: 4'h1, zone: 32'h0000_00A0, irq: 16'h0400, pme: 1'b0},
        '{pin: 5'd31, nib: 4'h7, zone: 32'hC000_0000, irq: 16'h1000, pme: 1'b0},
        '{pin: 5'd24, nib: 4'hA, zone: 32'h0000_0000, irq: 16'h0000, pme: 1'b1},
        '{pin: 5'd15, nib: 4'h2, zone: 32'h0000_0500, irq: 16'h0020, pme: 1'b0},
        '{pin: 5'd23, nib: 4'h4, zone: 32'h0003_0000, irq: 16'h0008, pme: 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    function automatic logic [31:0] field_word(input int pin, input logic [3:0] nib);
        return 32'(nib) << ((pin % 8) * 4);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 32'h0);
        end
        chk("R1 irq", {16'h0, irq_o}, 32'h0);
        chk("R1 pme", {31'h0, pme_o}, 32'h0);

        // Vector table: R4 R5 R6 R2 R3
        for (int v = 0; v < 8; v++) begin
            for (int m = 0; m < 4; m++) wr(3'(m), 32'h0);
            wr(3'd4, VECS[v].zone);
            wr(3'(VECS[v].pin / 8), field_word(VECS[v].pin, VECS[v].nib));
            pulse(32'h1 << VECS[v].pin);
            rd(3'd5, d);
            chk("R2 status", d, 32'h1 << VECS[v].pin);
            chk("R4 R6 irq", {16'h0, irq_o}, {16'h0, VECS[v].irq});
            chk("R5 pme", {31'h0, pme_o}, {31'h0, VECS[v].pme});
            wr(3'd5, 32'h1 << VECS[v].pin);
            chk("R3 cleared irq", {15'h0, pme_o, irq_o}, 32'h0);
        end

        // R7: two pins on one pair, partial clear keeps the line
        for (int m = 0; m < 4; m++) wr(3'(m), 32'h0);
        wr(3'd0, 32'h0000_0202);        // pins 0 and 2 -> pair 2
        wr(3'd4, 32'h0000_0900);        // pair 2 -> IRQ 9
        pulse(32'h0000_0005);
        chk("R7 shared", {16'h0, irq_o}, 32'h0000_0200);
        wr(3'd5, 32'h0000_0001);
        chk("R7 partial clear", {16'h0, irq_o}, 32'h0000_0200);
        wr(3'd5, 32'h0000_0004);
        chk("R7 full clear", {16'h0, irq_o}, 32'h0);

        // R7: two pairs to the same IRQ
        wr(3'd1, 32'h0000_0050);        // pin 9 -> pair 5
        wr(3'd4, 32'h0090_0900);        // pairs 2 and 5 -> IRQ 9
        pulse(32'h0000_0201);           // pins 0 and 9
        chk("R7 merge", {16'h0, irq_o}, 32'h0000_0200);

        // R8: remap pair 5 while pending
        wr(3'd4, 32'h0030_0900);
        chk("R8 remap", {16'h0, irq_o}, 32'h0000_0208);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R3 clear all", {16'h0, irq_o}, 32'h0);

        // R3: event and clear in the same cycle
        @(negedge clk);
        evt_i = 32'h1; wr_en_i = 1'b1; addr_i = 3'd5; wdata_i = 32'h1;
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0; wdata_i = '0;
        rd(3'd5, d);
        chk("R3 event wins", d, 32'h1);
        wr(3'd5, 32'h1);

        // R9: readback and unused addresses
        wr(3'd2, 32'hDEAD_BEEF);
        rd(3'd2, d);
        chk("R9 readback", d, 32'hDEAD_BEEF);
        wr(3'd6, 32'h1234_5678);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, d);
        chk("R9 addr6", d, 32'h0);
        rd(3'd7, d);
        chk("R9 addr7", d, 32'h0);
        rd(3'd2, d);
        chk("R9 no side effect", d, 32'hDEAD_BEEF);
        rd(3'd4, d);
        chk("R9 zone kept", d, 32'h0030_0900);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule